// File: doc/BRIEF.md
# Global-History Selected Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps a short shift register of the outcomes of the most recent resolved branches. The value of that register chooses one of several banks of 2-bit saturating counters. Low bits of the program counter pick the entry inside the chosen bank. Each counter learns the bias of the branches that map onto it for one particular recent-outcome pattern. The same branch address can therefore be predicted differently depending on how the preceding branches went.

The lookup side is purely combinational. Fetch presents a PC, and the taken/not-taken answer comes back in the same cycle from the bank that the current history names. When a branch resolves, the update side presents its PC and its actual outcome with a valid strobe. On the next clock edge, the addressed counter in the bank chosen by the history as it stood before that branch is trained. In the same edge, the outcome enters the history.

Top module: `gsel_predictor`

## Requirements
- R1: After reset every counter holds 01 (weakly not-taken) and the history holds all zeros, so every lookup answers not-taken.
- R2: The lookup answers taken exactly when the selected counter is 2 or 3, that is, when its upper bit is set.
- R3: The entry index is PC bits [IDX_BITS+1:2]. PC bits [1:0] and all bits above IDX_BITS+1 have no effect on which entry is read or trained.
- R4: The lookup reads the bank whose number equals the current history value. With HIST_BITS=2 there are four banks, numbered 0 to 3.
- R5: A valid update with outcome taken raises the addressed counter by one, and a counter already at 3 stays at 3.
- R6: A valid update with outcome not-taken lowers the addressed counter by one, and a counter already at 0 stays at 0.
- R7: The bank trained by an update is the one named by the history value before that update's outcome is shifted in.
- R8: On each valid update the history shifts toward its upper end by one place. The outcome (1 = taken) enters at bit 0, and the oldest bit leaves from the top.
- R9: While the update valid input is low, no counter and no history bit changes, whatever the other update inputs carry.
- R10: An update changes only the single addressed counter in the selected bank. All other entries keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PC_W | PC being fetched, for the prediction lookup |
| lk_taken | output | 1 | Combinational prediction: 1 = taken |
| up_valid | input | 1 | Strobe: a resolved branch is presented this cycle |
| up_pc | input | PC_W | PC of the resolved branch |
| up_taken | input | 1 | Actual outcome of the resolved branch: 1 = taken |

## Verification
The assertions assume that up_valid is a clean single-cycle strobe that is sampled only on rising edges, and that reset is held for at least one edge before any update arrives. They do not constrain the PC or outcome values at all. The stimulus drives every input on the falling edge and releases reset before the first update. Every valid strobe lasts exactly one cycle. During the idle stretches, the update PC and outcome are deliberately moved around with valid held low.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_INIT = 2'b01;
  localparam ctr_t CTR_MAX  = 2'b11;
  localparam ctr_t CTR_MIN  = 2'b00;

  // Saturating step of one 2-bit counter toward the resolved outcome.
  function automatic ctr_t ctr_step(input ctr_t cur, input logic went_taken);
    ctr_t nxt;
    if (went_taken) nxt = (cur == CTR_MAX) ? CTR_MAX : cur + 2'd1;
    else            nxt = (cur == CTR_MIN) ? CTR_MIN : cur - 2'd1;
    return nxt;
  endfunction

  // Direction encoded by a counter: its upper bit.
  function automatic logic ctr_dir(input ctr_t cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/ghist_reg.sv
module ghist_reg #(
  parameter int HIST_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shift_en,
  input  logic                 bit_in,
  output logic [HIST_BITS-1:0] hist_o
);

  logic [HIST_BITS-1:0] hist_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        hist_q <= '0;
    else if (shift_en) hist_q <= {hist_q[HIST_BITS-2:0], bit_in};
  end

  assign hist_o = hist_q;

endmodule

// File: rtl/bank_wdec.sv
module bank_wdec #(
  parameter int HIST_BITS = 2,
  localparam int BANKS    = 1 << HIST_BITS
) (
  input  logic                 fire,
  input  logic [HIST_BITS-1:0] sel,
  output logic [BANKS-1:0]     we
);

  always_comb begin
    we = '0;
    for (int b = 0; b < BANKS; b++) begin
      if (fire && (sel == HIST_BITS'(b))) we[b] = 1'b1;
    end
  end

endmodule

// File: rtl/ctr_bank.sv
module ctr_bank
  import bp_pkg::*;
#(
  parameter int IDX_BITS = 6,
  localparam int ENTRIES = 1 << IDX_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [IDX_BITS-1:0] wr_idx,
  input  logic                wr_taken,
  input  logic [IDX_BITS-1:0] rd_idx,
  output ctr_t                rd_ctr
);

  ctr_t tbl [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) tbl[e] <= CTR_INIT;
    end else if (we) begin
      tbl[wr_idx] <= ctr_step(tbl[wr_idx], wr_taken);
    end
  end

  assign rd_ctr = tbl[rd_idx];

endmodule

// File: rtl/gsel_predictor.sv
module gsel_predictor
  import bp_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int IDX_BITS  = 6,
  parameter int HIST_BITS = 2,
  localparam int BANKS    = 1 << HIST_BITS,
  localparam int IDX_LO   = 2,
  localparam int IDX_HI   = IDX_BITS + IDX_LO - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_taken,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken
);

  // Named internal events, visible to the bound checker.
  logic [HIST_BITS-1:0] hist_q;
  logic [BANKS-1:0]     bank_we;
  logic [IDX_BITS-1:0]  lk_idx;
  logic [IDX_BITS-1:0]  up_idx;
  logic                 upd_fire;
  ctr_t                 rd_ctr_all [BANKS];
  ctr_t                 pred_ctr;

  assign lk_idx   = lk_pc[IDX_HI:IDX_LO];
  assign up_idx   = up_pc[IDX_HI:IDX_LO];
  assign upd_fire = up_valid;

  logic unused_pc_bits;
  assign unused_pc_bits = ^{lk_pc[PC_W-1:IDX_HI+1], lk_pc[IDX_LO-1:0],
                            up_pc[PC_W-1:IDX_HI+1], up_pc[IDX_LO-1:0]};

  ghist_reg #(.HIST_BITS(HIST_BITS)) u_hist (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(upd_fire),
    .bit_in  (up_taken),
    .hist_o  (hist_q)
  );

  bank_wdec #(.HIST_BITS(HIST_BITS)) u_wdec (
    .fire(upd_fire),
    .sel (hist_q),
    .we  (bank_we)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    ctr_bank #(.IDX_BITS(IDX_BITS)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (bank_we[b]),
      .wr_idx  (up_idx),
      .wr_taken(up_taken),
      .rd_idx  (lk_idx),
      .rd_ctr  (rd_ctr_all[b])
    );
  end

  assign pred_ctr = rd_ctr_all[hist_q];
  assign lk_taken = ctr_dir(pred_ctr);

endmodule

// File: rtl/bp_checker.sv
module bp_checker #(
  parameter int HIST_BITS = 2,
  parameter int BANKS     = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 up_valid,
  input logic                 up_taken,
  input logic [HIST_BITS-1:0] hist_q,
  input logic [BANKS-1:0]     bank_we
);

  // R10: at most one bank is written per cycle
  p_one_bank_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_we));

  // R9: no bank write without a valid strobe
  p_idle_nowrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |-> (bank_we == '0));

  // R9: history holds while idle
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> $stable(hist_q));

  // R7: the written bank is the one the pre-shift history names
  p_bank_pick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |-> bank_we[hist_q]);

  // R8: newest outcome lands in bit 0
  p_shift_in_r8: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> (hist_q[0] == $past(up_taken)));

  // R8: older bits move up by one place
  p_shift_age_r8: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> (hist_q[HIST_BITS-1:1] == $past(hist_q[HIST_BITS-2:0])));

endmodule

bind gsel_predictor bp_checker #(.HIST_BITS(HIST_BITS), .BANKS(BANKS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .up_valid(up_valid),
  .up_taken(up_taken),
  .hist_q  (hist_q),
  .bank_we (bank_we)
);

// File: tb/sim_gsel_predictor.sv
`timescale 1ns/100ps
module sim_gsel_predictor;

  localparam int PC_W  = 32;
  localparam int IDX   = 3;
  localparam int HB    = 2;
  localparam int ENT   = 1 << IDX;
  localparam int NBANK = 1 << HB;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [PC_W-1:0] lk_pc;
  logic            lk_taken;
  logic            up_valid;
  logic [PC_W-1:0] up_pc;
  logic            up_taken;

  int errors = 0;
  int checks = 0;
  int mdl [NBANK][ENT];
  int hist;
  logic [31:0] lfsr = 32'hACE1_1234;

  always #4 clk = ~clk;

  gsel_predictor #(.PC_W(PC_W), .IDX_BITS(IDX), .HIST_BITS(HB)) u0 (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken)
  );

  function automatic logic [31:0] nxt(input logic [31:0] v);
    return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
  endfunction

  task automatic model_reset();
    for (int b = 0; b < NBANK; b++)
      for (int e = 0; e < ENT; e++) mdl[b][e] = 1;
    hist = 0;
  endtask

  task automatic model_update(input logic [PC_W-1:0] pc, input logic t);
    int e;
    e = (pc / 4) % ENT;
    if (t) mdl[hist][e] = (mdl[hist][e] == 3) ? 3 : mdl[hist][e] + 1;
    else   mdl[hist][e] = (mdl[hist][e] == 0) ? 0 : mdl[hist][e] - 1;
    hist = ((hist * 2) + (t ? 1 : 0)) % NBANK;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Sweep all entries of the bank named by the current history;
  // upper and lowest PC bits are scrambled each time.
  task automatic sweep(input string tag);
    for (int e = 0; e < ENT; e++) begin
      logic exp;
      lfsr  = nxt(lfsr);
      lk_pc = (lfsr & ~(32'(ENT - 1) << 2)) | (32'(e) << 2);
      #0.2;
      exp = (mdl[hist][e] >= 2);
      checks++;
      if (lk_taken !== exp) begin
        errors++;
        $display("FAIL %s: hist=%0d idx=%0d actual=%b expected=%b",
                 tag, hist, e, lk_taken, exp);
      end
    end
  endtask

  task automatic do_upd(input logic [PC_W-1:0] pc, input logic t);
    @(negedge clk);
    up_valid = 1'b1;
    up_pc    = pc;
    up_taken = t;
    @(posedge clk);
    model_update(pc, t);
    @(negedge clk);
    up_valid = 1'b0;
  endtask

  initial begin
    #(8ns * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; up_valid = 1'b0; up_pc = '0; up_taken = 1'b0; lk_pc = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    sweep("R1");

    // R5: repeated taken at entry 5 saturates bank 3 at 3
    for (int n = 0; n < 8; n++) begin
      do_upd(32'h0000_0014 | 32'(n) << 20, 1'b1);
      sweep("R5 R2");
    end
    // R6: drive not-taken until entries reach and hold 0
    for (int n = 0; n < 10; n++) begin
      do_upd(32'hF000_0017, 1'b0);
      sweep("R6 R2");
    end
    // R7 R8: alternating outcomes visit banks 1 and 2
    for (int n = 0; n < 12; n++) begin
      do_upd(32'h0000_0008 + 32'(n % 3) * 4, n[0]);
      sweep("R7 R8 R4");
    end
    // R9: idle stretch with moving update inputs
    for (int n = 0; n < 6; n++) begin
      @(negedge clk);
      lfsr = nxt(lfsr);
      up_pc = lfsr;
      up_taken = lfsr[3];
    end
    @(negedge clk);
    sweep("R9");

    // Near-exhaustive mixes: taken-biased then not-taken-biased
    for (int phase = 0; phase < 2; phase++) begin
      for (int n = 0; n < 160; n++) begin
        logic t;
        lfsr = nxt(lfsr);
        t = (phase == 0) ? (lfsr[5] | lfsr[9]) : (lfsr[5] & lfsr[9]);
        do_upd(lfsr, t);
        sweep("R3 R4 R10");
      end
    end
    finish_run();
  end

endmodule